// File: doc/BRIEF.md
# Slew-Rate Calibration Frequency Meter

This block sets the high-speed transmit slew rate of a serial link driver. It compares an on-chip ring oscillator with a fixed reference clock and turns the result into a small slew code. The oscillator side counts a programmed number of its own cycles. That window is carried into the reference domain through two-flop synchronizers. During the window the reference side counts its own cycles. The block then reports this raw count together with a valid flag.

When the count is valid, a sequential divider forms the quotient (reference MHz × coefficient × 1024) / count. A bank of threshold comparators rounds that quotient to the nearest multiple of 1000, giving the slew code. A count of zero gives a fixed default code. When a nonzero override code is programmed, it replaces the measured code and no measurement is started.

Software drives the control inputs in a fixed order. It enables the oscillator, then the free-running clock, then the meter. It then polls the valid flag, reads the count and waits for the code. It clears the meter enable and finally turns off the free-running clock and the oscillator.

Top module: `slewcal_fmeter`

## Requirements
- R1: A measurement is armed only by a rising edge of `meter_en` that arrives while `cal_en` and `frun_en` are already high and `force_code` is zero. If `meter_en` rises before `frun_en`, no measurement runs and `fm_valid` stays low.
- R2: The oscillator window lasts `cycle_cnt` cycles of `osc_clk`. `fm_count` is the number of reference cycles inside that window, within ±3 of the window length divided by the reference period.
- R3: `fm_count` saturates at 2^CNT_W−1 and holds that value while the meter stays enabled.
- R4: `fm_valid` rises after the window ends and stays high while `meter_en` stays high. From then on `fm_count` does not change.
- R5: Two reference cycles after `meter_en` goes low, `fm_valid`, `code_done` and `fm_count` read 0.
- R6: For a nonzero count, `slew_code` = min(7, floor((floor(ref_mhz·coef·1024 / fm_count) + 500) / 1000)). This is a round-half-up of the scaled reciprocal, saturated to the 3-bit field.
- R7: When the window ends with a count of zero (as it does when `cycle_cnt` = 0), the code is 3.
- R8: While `force_code` is nonzero, `slew_code` equals `force_code` and no measurement runs (`fm_valid` stays low). Once it returns to zero, the last computed code shows again.
- R9: `code_done` rises within NUM_W+6 reference cycles after `fm_valid` rises and is only high while `fm_valid` is high. The computed code is kept after the meter is disabled.
- R10: `ref_mhz` and `coef` are inputs. Changing them changes the code according to the R6 formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Ring-oscillator clock being measured |
| cal_en | input | 1 | Oscillator enable for calibration |
| frun_en | input | 1 | Free-running clock enable |
| meter_en | input | 1 | Frequency-meter enable; clearing it resets the meter |
| cycle_cnt | input | CNT_W | Window length in oscillator cycles |
| force_code | input | CODE_W | Override slew code; zero selects the measured code |
| ref_mhz | input | REF_W | Reference frequency in MHz |
| coef | input | COEF_W | Slew-rate scaling coefficient |
| fm_count | output | CNT_W | Reference cycles counted during the window |
| fm_valid | output | 1 | Measurement complete |
| slew_code | output | CODE_W | Slew-rate code to the transmitter |
| code_done | output | 1 | Code computed for the current measurement |

## Verification
The bench builds the block with CNT_W = 12 and keeps the 8-bit reference and coefficient widths. With a 12-bit count, an oscillator about twenty times slower than the reference saturates the counter within a few thousand cycles. The oscillator period is changed from run to run, so the same bench reaches the saturated code 7, a zero code and a mid-range code. A window length of zero produces the default-code path.

// File: rtl/slewcal_pkg.sv
`timescale 1ns/1ps
package slewcal_pkg;
  typedef enum logic [1:0] {
    CALC_IDLE,
    CALC_DIV,
    CALC_RND,
    CALC_DONE
  } calc_state_e;
endpackage

// File: rtl/slewcal_sync2.sv
`timescale 1ns/1ps
module slewcal_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/slewcal_osc_window.sv
`timescale 1ns/1ps
module slewcal_osc_window #(
  parameter int CNT_W = 24
) (
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  input  logic             arm_s,
  input  logic [CNT_W-1:0] cycle_cnt,
  output logic             win_open,
  output logic             win_done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             done_q, done_d;
  logic             started_q, started_d;

  always_comb begin
    cnt_d     = cnt_q;
    open_d    = open_q;
    done_d    = done_q;
    started_d = started_q;
    if (!arm_s) begin
      cnt_d     = '0;
      open_d    = 1'b0;
      done_d    = 1'b0;
      started_d = 1'b0;
    end else if (!started_q) begin
      started_d = 1'b1;
      if (cycle_cnt == '0) begin
        done_d = 1'b1;
      end else begin
        open_d = 1'b1;
        cnt_d  = CNT_W'(1);
      end
    end else if (open_q) begin
      if (cnt_q == cycle_cnt) begin
        open_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      cnt_q     <= '0;
      open_q    <= 1'b0;
      done_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      open_q    <= open_d;
      done_q    <= done_d;
      started_q <= started_d;
    end
  end

  assign win_open = open_q;
  assign win_done = done_q;
endmodule

// File: rtl/slewcal_ref_counter.sv
`timescale 1ns/1ps
module slewcal_ref_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             open_s,
  input  logic             done_s,
  output logic [CNT_W-1:0] count,
  output logic             valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic             valid_q, valid_d;
  logic             count_en;

  assign count_en = armed && open_s && (count_q != CNT_MAX);

  always_comb begin
    count_d = count_q;
    valid_d = armed && done_s;
    if (!armed) begin
      count_d = '0;
    end else if (count_en) begin
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      valid_q <= 1'b0;
    end else begin
      count_q <= count_d;
      valid_q <= valid_d;
    end
  end

  assign count = count_q;
  assign valid = valid_q;
endmodule

// File: rtl/slewcal_code_calc.sv
`timescale 1ns/1ps
module slewcal_code_calc
  import slewcal_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int REF_W    = 8,
  parameter int COEF_W   = 8,
  parameter int CAL_WIN  = 1024,
  parameter int DIVISOR  = 1000,
  parameter int CODE_W   = 3,
  parameter int DEF_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              valid,
  input  logic [CNT_W-1:0]  count,
  input  logic [REF_W-1:0]  ref_mhz,
  input  logic [COEF_W-1:0] coef,
  output logic [CODE_W-1:0] code,
  output logic              done
);
  localparam int NUM_W  = REF_W + COEF_W + $clog2(CAL_WIN) + 1;
  localparam int RW     = NUM_W + 2;
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int NCODE  = (1 << CODE_W) - 1;
  localparam int HALF   = DIVISOR / 2;

  calc_state_e       st_q, st_d;
  logic [NUM_W-1:0]  sh_q, sh_d;
  logic [NUM_W-1:0]  quo_q, quo_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [NUM_W-1:0]  numer;
  logic [CNT_W:0]    trial;
  logic              fits;
  logic [RW-1:0]     rounded;
  logic [NCODE-1:0]  hit;
  logic [CODE_W-1:0] code_rnd;

  assign numer   = NUM_W'(ref_mhz) * NUM_W'(coef) * NUM_W'(CAL_WIN);
  assign trial   = {rem_q, sh_q[NUM_W-1]};
  assign fits    = trial >= {1'b0, count};
  assign rounded = RW'(quo_q) + RW'(HALF);

  for (genvar k = 1; k <= NCODE; k++) begin : g_thr
    assign hit[k-1] = rounded >= RW'(k * DIVISOR);
  end

  always_comb begin
    code_rnd = '0;
    for (int i = 0; i < NCODE; i++) begin
      if (hit[i]) code_rnd = code_rnd + CODE_W'(1);
    end
  end

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    quo_d  = quo_q;
    rem_d  = rem_q;
    step_d = step_q;
    code_d = code_q;
    if (!armed) begin
      st_d = CALC_IDLE;
    end else begin
      unique case (st_q)
        CALC_IDLE: begin
          if (valid) begin
            if (count == '0) begin
              code_d = CODE_W'(DEF_CODE);
              st_d   = CALC_DONE;
            end else begin
              sh_d   = numer;
              quo_d  = '0;
              rem_d  = '0;
              step_d = STEP_W'(NUM_W - 1);
              st_d   = CALC_DIV;
            end
          end
        end
        CALC_DIV: begin
          sh_d  = {sh_q[NUM_W-2:0], 1'b0};
          quo_d = {quo_q[NUM_W-2:0], fits};
          rem_d = fits ? CNT_W'(trial - {1'b0, count}) : CNT_W'(trial);
          if (step_q == '0) st_d = CALC_RND;
          else step_d = step_q - STEP_W'(1);
        end
        CALC_RND: begin
          code_d = code_rnd;
          st_d   = CALC_DONE;
        end
        default: st_d = CALC_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CALC_IDLE;
      sh_q   <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      step_q <= '0;
      code_q <= '0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      step_q <= step_d;
      code_q <= code_d;
    end
  end

  assign code = code_q;
  assign done = (st_q == CALC_DONE);
endmodule

// File: rtl/slewcal_fmeter.sv
`timescale 1ns/1ps
module slewcal_fmeter #(
  parameter int CNT_W    = 24,
  parameter int REF_W    = 8,
  parameter int COEF_W   = 8,
  parameter int CAL_WIN  = 1024,
  parameter int DIVISOR  = 1000,
  parameter int CODE_W   = 3,
  parameter int DEF_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_clk,
  input  logic              cal_en,
  input  logic              frun_en,
  input  logic              meter_en,
  input  logic [CNT_W-1:0]  cycle_cnt,
  input  logic [CODE_W-1:0] force_code,
  input  logic [REF_W-1:0]  ref_mhz,
  input  logic [COEF_W-1:0] coef,
  output logic [CNT_W-1:0]  fm_count,
  output logic              fm_valid,
  output logic [CODE_W-1:0] slew_code,
  output logic              code_done
);
  logic              ref_rst_n;
  logic              osc_rst_n;
  logic              arm_q, arm_d;
  logic              meter_prev_q;
  logic              arm_s;
  logic              win_open;
  logic              win_done;
  logic [1:0]        win_s;
  logic [CODE_W-1:0] meas_code;
  logic              forced;

  slewcal_sync2 #(.W(1)) u_ref_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n)
  );
  slewcal_sync2 #(.W(1)) u_osc_rst (
    .clk(osc_clk), .rst_n(rst_n), .d(1'b1), .q(osc_rst_n)
  );

  assign forced = (force_code != '0);

  always_comb begin
    arm_d = arm_q;
    if (!meter_en || !cal_en || !frun_en || forced) begin
      arm_d = 1'b0;
    end else if (!meter_prev_q) begin
      arm_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      arm_q        <= 1'b0;
      meter_prev_q <= 1'b0;
    end else begin
      arm_q        <= arm_d;
      meter_prev_q <= meter_en;
    end
  end

  slewcal_sync2 #(.W(1)) u_arm_sync (
    .clk(osc_clk), .rst_n(osc_rst_n), .d(arm_q), .q(arm_s)
  );

  slewcal_osc_window #(.CNT_W(CNT_W)) u_win (
    .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .arm_s(arm_s),
    .cycle_cnt(cycle_cnt), .win_open(win_open), .win_done(win_done)
  );

  slewcal_sync2 #(.W(2)) u_win_sync (
    .clk(clk), .rst_n(ref_rst_n), .d({win_done, win_open}), .q(win_s)
  );

  slewcal_ref_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(ref_rst_n), .armed(arm_q),
    .open_s(win_s[0]), .done_s(win_s[1]),
    .count(fm_count), .valid(fm_valid)
  );

  slewcal_code_calc #(
    .CNT_W(CNT_W), .REF_W(REF_W), .COEF_W(COEF_W), .CAL_WIN(CAL_WIN),
    .DIVISOR(DIVISOR), .CODE_W(CODE_W), .DEF_CODE(DEF_CODE)
  ) u_calc (
    .clk(clk), .rst_n(ref_rst_n), .armed(arm_q), .valid(fm_valid),
    .count(fm_count), .ref_mhz(ref_mhz), .coef(coef),
    .code(meas_code), .done(code_done)
  );

  assign slew_code = forced ? force_code : meas_code;
endmodule

// File: rtl/slewcal_fmeter_chk.sv
`timescale 1ns/1ps
module slewcal_fmeter_chk #(
  parameter int CNT_W    = 24,
  parameter int CODE_W   = 3,
  parameter int DEF_CODE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_en,
  input logic              frun_en,
  input logic              meter_en,
  input logic [CODE_W-1:0] force_code,
  input logic [CNT_W-1:0]  fm_count,
  input logic              fm_valid,
  input logic [CODE_W-1:0] slew_code,
  input logic              code_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_arm_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fm_valid) |-> (cal_en && frun_en));

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_count == CNT_MAX) && meter_en |=> (fm_count == CNT_MAX));

  p_count_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fm_valid && meter_en |=> $stable(fm_count));

  p_meter_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !meter_en && $past(!meter_en) && $past(!meter_en, 2)
      |-> (!fm_valid && !code_done && fm_count == '0));

  p_zero_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    code_done && (fm_count == '0) && (force_code == '0)
      |-> (slew_code == CODE_W'(DEF_CODE)));

  p_force_no_meas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_code != '0) && $past(force_code != '0) && $past(force_code != '0, 2)
      |-> !fm_valid);

  p_done_in_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code_done |-> fm_valid);
endmodule

bind slewcal_fmeter slewcal_fmeter_chk #(
  .CNT_W(CNT_W), .CODE_W(CODE_W), .DEF_CODE(DEF_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .frun_en(frun_en),
  .meter_en(meter_en), .force_code(force_code), .fm_count(fm_count),
  .fm_valid(fm_valid), .slew_code(slew_code), .code_done(code_done)
);

// File: tb/sim_slewcal_fmeter.sv
`timescale 1ns/1ps
module sim_slewcal_fmeter;
  localparam int CLK_PERIOD = 20;
  localparam int CNT_W  = 12;
  localparam int REF_W  = 8;
  localparam int COEF_W = 8;
  localparam int CODE_W = 3;
  localparam int NUM_W  = REF_W + COEF_W + 11;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int WDOG   = 150000;

  logic clk, rst_n, osc_clk;
  logic cal_en, frun_en, meter_en;
  logic [CNT_W-1:0]  cycle_cnt;
  logic [CODE_W-1:0] force_code;
  logic [REF_W-1:0]  ref_mhz;
  logic [COEF_W-1:0] coef;
  logic [CNT_W-1:0]  fm_count;
  logic              fm_valid;
  logic [CODE_W-1:0] slew_code;
  logic              code_done;

  real osc_half;
  int  n_chk, n_bad, cyc;
  logic done_flag;

  slewcal_fmeter #(.CNT_W(CNT_W), .REF_W(REF_W), .COEF_W(COEF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .cal_en(cal_en),
    .frun_en(frun_en), .meter_en(meter_en), .cycle_cnt(cycle_cnt),
    .force_code(force_code), .ref_mhz(ref_mhz), .coef(coef),
    .fm_count(fm_count), .fm_valid(fm_valid), .slew_code(slew_code),
    .code_done(code_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;
  initial begin
    osc_half = 1.5;
    osc_clk  = 1'b0;
  end
  always #(osc_half) osc_clk = ~osc_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_code(input int cnt, input int r, input int c);
    int q, k;
    if (cnt == 0) return 3;
    q = (r * c * 1024) / cnt;
    k = (q + 500) / 1000;
    if (k > 7) k = 7;
    return k;
  endfunction

  // Full calibration sequence; covers R2, R3, R4, R5, R6, R7, R9, R10
  task automatic run_meas(input int cycles, input int r, input int c, input real half,
                          input string tag);
    int  waited, cnt, code_seen, ec;
    real expc;
    osc_half  = half;
    cycle_cnt = CNT_W'(cycles);
    ref_mhz   = REF_W'(r);
    coef      = COEF_W'(c);
    tick(4);
    cal_en = 1'b1;  tick(3);
    frun_en = 1'b1; tick(3);
    meter_en = 1'b1;
    waited = 0;
    while (!fm_valid && waited < 20000) begin tick(1); waited++; end
    check(fm_valid, {tag, " R4 valid raised"}, fm_valid, 1);
    cnt = fm_count;
    expc = (cycles * 2.0 * half) / CLK_PERIOD;
    if (expc > CNT_MAX - 3)
      check(cnt == CNT_MAX, {tag, " R3 count saturates"}, cnt, CNT_MAX);
    else
      check((cnt >= expc - 3.0) && (cnt <= expc + 3.0), {tag, " R2 count range"},
            cnt, int'(expc));
    waited = 0;
    while (!code_done && waited < NUM_W + 6) begin tick(1); waited++; end
    check(code_done, {tag, " R9 done in time"}, waited, NUM_W + 6);
    ec = exp_code(cnt, r, c);
    check(slew_code == CODE_W'(ec), {tag, " R6 R7 R10 code"}, slew_code, ec);
    check(fm_count == CNT_W'(cnt), {tag, " R4 count frozen"}, fm_count, cnt);
    code_seen = slew_code;
    meter_en = 1'b0;
    tick(3);
    check(!fm_valid && !code_done && fm_count == '0, {tag, " R5 meter clear"},
          {fm_valid, code_done}, 0);
    check(fm_count == '0, {tag, " R5 count cleared"}, fm_count, 0);
    check(slew_code == CODE_W'(code_seen), {tag, " R9 code kept"}, slew_code, code_seen);
    frun_en = 1'b0; tick(2);
    cal_en  = 1'b0; tick(10);
  endtask

  task automatic t_reset;
    check(fm_valid == 1'b0, "R4 reset valid", fm_valid, 0);
    check(fm_count == '0, "R5 reset count", fm_count, 0);
    check(code_done == 1'b0, "R9 reset done", code_done, 0);
    check(slew_code == '0, "R8 reset code", slew_code, 0);
  endtask

  // R1: meter enabled before the free-running clock -> no measurement
  task automatic t_bad_order;
    osc_half = 1.5; cycle_cnt = CNT_W'(100);
    cal_en = 1'b1;   tick(3);
    meter_en = 1'b1; tick(3);
    frun_en = 1'b1;  tick(300);
    check(!fm_valid, "R1 out-of-order enable ignored", fm_valid, 0);
    check(fm_count == '0, "R1 no count accumulated", fm_count, 0);
    meter_en = 1'b0; frun_en = 1'b0; cal_en = 1'b0; tick(10);
  endtask

  // R8: forced code bypasses measurement
  task automatic t_force(input int prev_code);
    force_code = CODE_W'(5);
    osc_half = 1.5; cycle_cnt = CNT_W'(100);
    tick(2);
    check(slew_code == CODE_W'(5), "R8 forced code out", slew_code, 5);
    cal_en = 1'b1; tick(3); frun_en = 1'b1; tick(3); meter_en = 1'b1;
    tick(300);
    check(!fm_valid, "R8 no measurement while forced", fm_valid, 0);
    meter_en = 1'b0; frun_en = 1'b0; cal_en = 1'b0;
    force_code = '0; tick(3);
    check(slew_code == CODE_W'(prev_code), "R8 measured code returns", slew_code, prev_code);
    tick(10);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done_flag = 1'b0;
    rst_n = 1'b0; cal_en = 1'b0; frun_en = 1'b0; meter_en = 1'b0;
    cycle_cnt = '0; force_code = '0; ref_mhz = REF_W'(26); coef = COEF_W'(17);
    tick(5);
    t_reset;
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_bad_order;
    run_meas(1024, 26, 17, 1.5, "nominal");
    run_meas(1024, 52, 17, 1.5, "ref52");
    run_meas(1024, 26, 9, 2.0, "coef9");
    run_meas(400, 26, 17, 1.5, "short-sat7");
    run_meas(0, 26, 17, 1.5, "zero-window");
    run_meas(300, 26, 17, 200.0, "saturate");
    t_force(0);
    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc = 0;
    while (!done_flag) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG && !done_flag) begin
        n_chk++; n_bad++;
        $display("FAIL R4 watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule